// File: doc/BRIEF.md
# Serial Command Front End for a Digital Potentiometer

This block is the slave-side command engine of a serial-controlled resistor chip. It watches a four-wire serial port (clock, data in, active-low select, active-low pause) and two strap pins, and it drives a data-out line with a separate output enable. It oversamples the serial pins in a system clock at least eight times faster than the serial clock, and it assembles bytes from the samples. The first byte after select falls must carry the device type and the strap address. The second byte carries the opcode and the register and bank pointers.

The decoder runs the resulting command: a fixed two- or three-byte exchange, or an open-ended stream of single-step wiper moves. Register storage lives in neighbouring blocks. The decoder hands them pointers, write data and one-cycle strobes, and it serializes the value they present back onto the data-out line for read commands. A pause input freezes the serial sequence mid-command without losing its place.

Top module: `spi_pot_decoder`

## Requirements
- R1: The first byte after a select high-to-low edge is accepted only if it equals {4'b0101, 2'b00, strap[1], strap[0]}, sent MSB first; any other value makes the decoder ignore all bits and issue no strobe until select rises.
- R2: The second byte's top nibble is the opcode: 4'b1001 read wiper, 4'b1010 write wiper, 4'b1011 read register, 4'b1100 write register, 4'b1101 register-to-wiper, 4'b1110 wiper-to-register, 4'b0010 step, 4'b0101 read status. Any other nibble is ignored until select rises and issues no strobe.
- R3: After the second byte, reg_sel takes its bits [3:2] and bank_sel takes its bits [1:0].
- R4: Write wiper and write register each take a third data byte. On the select rise that follows exactly 24 serial clocks, they pulse wiper_load or dreg_store with that byte on wr_data. Fewer or more clocks abort the command.
- R5: The two transfer commands are two bytes long and pulse dreg_to_wiper or wiper_to_dreg on the select rise after exactly 16 clocks, only when bank bits [1:0] are 00. Any other bank value is ignored.
- R6: Read commands shift the third byte out MSB first, changing only on falling serial clock edges: read wiper returns wiper_q, read register returns dreg_q, and read status returns {7'b0, wip}.
- R7: so_oe is low whenever select is high, pause is low, or the current command is not a read.
- R8: After a step opcode, each rising serial clock pulses step_up if SI is 1 and step_dn if SI is 0, until select rises. Clocks after that rise have no effect.
- R9: While pause is low, serial clock edges are ignored and so_oe is low. Releasing pause resumes the command where it stopped.
- R10: After reset, a command is not decoded until select has been seen high and then falls.
- R11: Every strobe lasts one system clock, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in, taken on rising sck |
| cs_n | input | 1 | Active-low select |
| hold_n | input | 1 | Active-low pause |
| strap | input | 2 | Device address straps |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so (high = driven) |
| wiper_q | input | 8 | Current wiper value from wiper block |
| dreg_q | input | 8 | Data register addressed by reg_sel/bank_sel |
| wip | input | 1 | Store-in-progress flag from register block |
| reg_sel | output | 2 | Register pointer from instruction byte |
| bank_sel | output | 2 | Bank pointer from instruction byte |
| wr_data | output | 8 | Data byte for write strobes |
| wiper_load | output | 1 | Write wiper strobe |
| dreg_store | output | 1 | Write register strobe |
| dreg_to_wiper | output | 1 | Register-to-wiper transfer strobe |
| wiper_to_dreg | output | 1 | Wiper-to-register transfer strobe |
| step_up | output | 1 | Move wiper one step up |
| step_dn | output | 1 | Move wiper one step down |

## Verification
A wrong phase or bit count inside the decoder shows up at the ports on the very next select rise: a strobe appears that should not, or one that should appears not at all. A misloaded or misaligned read shifter shows as a wrong byte on so within the eight clocks of the third byte. A pause that fails to freeze the count shifts every later bit, so the command's data byte or strobe is wrong at its end. The sweeps cover every opcode, several pointer values and a grid of identification bytes, so a wrong decode shows up as a missing or extra strobe count.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;

  localparam logic [3:0] DEVICE_TYPE = 4'b0101;

  localparam logic [3:0] OP_STEP       = 4'b0010;
  localparam logic [3:0] OP_STATUS     = 4'b0101;
  localparam logic [3:0] OP_RD_WIPER   = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER   = 4'b1010;
  localparam logic [3:0] OP_RD_REG     = 4'b1011;
  localparam logic [3:0] OP_WR_REG     = 4'b1100;
  localparam logic [3:0] OP_REG2WIPER  = 4'b1101;
  localparam logic [3:0] OP_WIPER2REG  = 4'b1110;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ID, PH_INSTR, PH_DATA, PH_STEP, PH_DONE, PH_IGNORE
  } phase_e;

  function automatic logic op_is_read(input logic [3:0] op);
    return (op == OP_RD_WIPER) || (op == OP_RD_REG) || (op == OP_STATUS);
  endfunction

endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d_in;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/spi_pot_rx.sv
module spi_pot_rx #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            take,
  input  logic            bit_in,
  output logic [BITS-1:0] byte_q,
  output logic            byte_done
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt       <= '0;
      byte_q    <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (take) begin
        byte_q <= {byte_q[BITS-2:0], bit_in};
        if (cnt == LAST) begin
          cnt       <= '0;
          byte_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9: with no accepted edge the bit position does not move
  assert_count_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (!take && !clr) |=> $stable(cnt));
endmodule

// File: rtl/spi_pot_tx.sv
module spi_pot_tx #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BITS-1:0] load_val,
  input  logic            shift,
  output logic            bit_out
);
  logic [BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      bit_out <= 1'b0;
    end else if (load) begin
      sh      <= load_val;
      bit_out <= 1'b0;
    end else if (shift) begin
      bit_out <= sh[BITS-1];
      sh      <= {sh[BITS-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_pot_decoder.sv
module spi_pot_decoder
  import spi_pot_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STRAP_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              si,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic [STRAP_W-1:0] strap,
  output logic              so,
  output logic              so_oe,
  input  logic [DATA_W-1:0] wiper_q,
  input  logic [DATA_W-1:0] dreg_q,
  input  logic              wip,
  output logic [1:0]        reg_sel,
  output logic [1:0]        bank_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic              wiper_load,
  output logic              dreg_store,
  output logic              dreg_to_wiper,
  output logic              wiper_to_dreg,
  output logic              step_up,
  output logic              step_dn
);
  localparam int PAD_W = DATA_W - 4 - STRAP_W;

  logic [3:0] pins_s;
  logic sck_s, si_s, csn_s, holdn_s;
  logic sck_d, csn_d;

  spi_pot_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_in({sck, si, cs_n, hold_n}),
    .d_out(pins_s)
  );
  assign {sck_s, si_s, csn_s, holdn_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      csn_d <= 1'b0;
    end else begin
      sck_d <= sck_s;
      csn_d <= csn_s;
    end
  end

  logic live, sck_rise, sck_fall, cs_fall, cs_rise;
  assign live     = !csn_s && holdn_s;
  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;
  assign cs_fall  = !csn_s && csn_d;
  assign cs_rise  = csn_s && !csn_d;

  phase_e             phase;
  logic [3:0]         op_q;
  logic               rx_take, rx_done, tx_load, tx_shift, reading;
  logic [DATA_W-1:0]  rx_byte, tx_val;
  logic [DATA_W-1:0]  id_expect;

  assign id_expect = {DEVICE_TYPE, {PAD_W{1'b0}}, strap};
  assign reading   = op_is_read(op_q);
  assign rx_take   = sck_rise && live &&
                     (phase == PH_ID || phase == PH_INSTR || phase == PH_DATA);
  assign tx_shift  = sck_fall && live && reading && (phase == PH_DATA);

  spi_pot_rx #(.BITS(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .clr(cs_fall || cs_rise),
    .take(rx_take), .bit_in(si_s),
    .byte_q(rx_byte), .byte_done(rx_done)
  );

  always_comb begin
    case (op_q)
      OP_RD_WIPER: tx_val = wiper_q;
      OP_RD_REG:   tx_val = dreg_q;
      OP_STATUS:   tx_val = {{(DATA_W-1){1'b0}}, wip};
      default:     tx_val = '0;
    endcase
  end

  spi_pot_tx #(.BITS(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .load_val(tx_val),
    .shift(tx_shift), .bit_out(so)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase         <= PH_IDLE;
      op_q          <= '0;
      reg_sel       <= '0;
      bank_sel      <= '0;
      wr_data       <= '0;
      tx_load       <= 1'b0;
      so_oe         <= 1'b0;
      wiper_load    <= 1'b0;
      dreg_store    <= 1'b0;
      dreg_to_wiper <= 1'b0;
      wiper_to_dreg <= 1'b0;
      step_up       <= 1'b0;
      step_dn       <= 1'b0;
    end else begin
      tx_load       <= 1'b0;
      wiper_load    <= 1'b0;
      dreg_store    <= 1'b0;
      dreg_to_wiper <= 1'b0;
      wiper_to_dreg <= 1'b0;
      step_up       <= 1'b0;
      step_dn       <= 1'b0;
      so_oe         <= live && reading && (phase == PH_DATA || phase == PH_DONE);

      if (cs_rise) begin
        if (phase == PH_DONE) begin
          case (op_q)
            OP_WR_WIPER:  wiper_load    <= 1'b1;
            OP_WR_REG:    dreg_store    <= 1'b1;
            OP_REG2WIPER: dreg_to_wiper <= 1'b1;
            OP_WIPER2REG: wiper_to_dreg <= 1'b1;
            default: ;
          endcase
        end
        phase <= PH_IDLE;
      end else if (cs_fall) begin
        phase <= PH_ID;
      end else begin
        case (phase)
          PH_ID: if (rx_done)
            phase <= (rx_byte == id_expect) ? PH_INSTR : PH_IGNORE;
          PH_INSTR: if (rx_done) begin
            op_q     <= rx_byte[DATA_W-1 -: 4];
            reg_sel  <= rx_byte[3:2];
            bank_sel <= rx_byte[1:0];
            case (rx_byte[DATA_W-1 -: 4])
              OP_RD_WIPER, OP_RD_REG, OP_STATUS: begin
                phase   <= PH_DATA;
                tx_load <= 1'b1;
              end
              OP_WR_WIPER, OP_WR_REG: phase <= PH_DATA;
              OP_REG2WIPER, OP_WIPER2REG:
                phase <= (rx_byte[1:0] == 2'b00) ? PH_DONE : PH_IGNORE;
              OP_STEP: phase <= PH_STEP;
              default: phase <= PH_IGNORE;
            endcase
          end
          PH_DATA: if (rx_done) begin
            wr_data <= rx_byte;
            phase   <= PH_DONE;
          end
          PH_STEP: if (sck_rise && live) begin
            step_up <= si_s;
            step_dn <= !si_s;
          end
          PH_DONE: if (sck_rise && live) phase <= PH_IGNORE;
          default: ;
        endcase
      end
    end
  end

  // R11: strobes never overlap
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wiper_load, dreg_store, dreg_to_wiper, wiper_to_dreg, step_up, step_dn}));

  // R11: a strobe is never two cycles wide
  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (rst)
    (wiper_load || dreg_store || dreg_to_wiper || wiper_to_dreg) |=>
    !(wiper_load || dreg_store || dreg_to_wiper || wiper_to_dreg));

  // R4 / R5: committing strobes only follow a select release
  assert_commit_on_release_R4: assert property (@(posedge clk) disable iff (rst)
    (wiper_load || dreg_store || dreg_to_wiper || wiper_to_dreg) |-> $past(cs_rise));

  // R8: step pulses only come out of the step phase
  assert_step_in_phase_R8: assert property (@(posedge clk) disable iff (rst)
    (step_up || step_dn) |-> $past(phase == PH_STEP));

  // R7: the output is driven only after a read reached its data phase
  assert_oe_read_only_R7: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> $past(phase == PH_DATA || phase == PH_DONE));
endmodule

// File: tb/spi_pot_decoder_test.sv
module spi_pot_decoder_test;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b0, hold_n = 1'b1;
  logic [1:0] strap = 2'b10;
  logic so, so_oe, wip = 1'b0;
  logic [7:0] wiper_q = 8'hC6;
  logic [7:0] dreg_q;
  logic [1:0] reg_sel, bank_sel;
  logic [7:0] wr_data;
  logic wiper_load, dreg_store, dreg_to_wiper, wiper_to_dreg, step_up, step_dn;

  always #2 clk = ~clk;

  assign dreg_q = {bank_sel, reg_sel, 4'h3} ^ 8'h5A;

  spi_pot_decoder uut (
    .clk(clk), .rst(rst), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
    .strap(strap), .so(so), .so_oe(so_oe), .wiper_q(wiper_q), .dreg_q(dreg_q),
    .wip(wip), .reg_sel(reg_sel), .bank_sel(bank_sel), .wr_data(wr_data),
    .wiper_load(wiper_load), .dreg_store(dreg_store), .dreg_to_wiper(dreg_to_wiper),
    .wiper_to_dreg(wiper_to_dreg), .step_up(step_up), .step_dn(step_dn)
  );

  int total = 0, bad = 0, so_glitch = 0;
  int cnt [6];
  int base [6];
  logic [7:0] last_wd = 8'h00;
  bit finished = 0;

  initial for (int i = 0; i < 6; i++) cnt[i] = 0;

  always @(posedge clk) begin
    if (wiper_load)    begin cnt[0] <= cnt[0] + 1; last_wd <= wr_data; end
    if (dreg_store)    begin cnt[1] <= cnt[1] + 1; last_wd <= wr_data; end
    if (dreg_to_wiper) cnt[2] <= cnt[2] + 1;
    if (wiper_to_dreg) cnt[3] <= cnt[3] + 1;
    if (step_up)       cnt[4] <= cnt[4] + 1;
    if (step_dn)       cnt[5] <= cnt[5] + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic snap();
    for (int i = 0; i < 6; i++) base[i] = cnt[i];
  endtask

  task automatic chk_delta(input string req, input int e0, input int e1, input int e2,
                           input int e3, input int e4, input int e5);
    chk(req, cnt[0] - base[0], e0);
    chk(req, cnt[1] - base[1], e1);
    chk(req, cnt[2] - base[2], e2);
    chk(req, cnt[3] - base[3], e3);
    chk(req, cnt[4] - base[4], e4);
    chk(req, cnt[5] - base[5], e5);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_bit(input logic b, output logic seen);
    logic after;
    @(negedge clk) si = b;
    wait_n(HALF);
    seen = so;
    sck = 1'b1;
    wait_n(3);
    after = so;
    if (so_oe && after !== seen) so_glitch++;
    wait_n(HALF - 3);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic [7:0] got);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      sck_bit(v[i], b);
      got[i] = b;
    end
  endtask

  task automatic cs_start();
    @(negedge clk) cs_n = 1'b0;
    wait_n(8);
  endtask

  task automatic cs_end();
    wait_n(6);
    cs_n = 1'b1;
    wait_n(14);
  endtask

  task automatic pause_toggle(input logic sv);
    @(negedge clk) hold_n = 1'b0;
    wait_n(6);
    chk("R9 so_oe during pause", int'(so_oe), 0);
    si = sv;
    for (int k = 0; k < 2; k++) begin
      sck = 1'b1; wait_n(HALF);
      sck = 1'b0; wait_n(HALF);
    end
    hold_n = 1'b1;
    wait_n(6);
  endtask

  logic [7:0] idb;
  logic [7:0] got;
  logic       b1;

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(3);
    // reset state
    chk("R7 reset so_oe", int'(so_oe), 0);
    chk("R11 reset strobes", int'({wiper_load, dreg_store, dreg_to_wiper,
                                   wiper_to_dreg, step_up, step_dn}), 0);
    chk("R3 reset pointers", int'({reg_sel, bank_sel}), 0);

    // R10: select low since before reset: not decoded
    snap();
    idb = {4'b0101, 2'b00, strap};
    send_byte(idb, got);
    send_byte(8'hA0, got);
    send_byte(8'h77, got);
    cs_end();
    chk_delta("R10 no command without select fall", 0, 0, 0, 0, 0, 0);
    snap();
    cs_start();
    send_byte(idb, got);
    send_byte(8'hA0, got);
    send_byte(8'h77, got);
    cs_end();
    chk_delta("R10 command after select fall", 1, 0, 0, 0, 0, 0);
    chk("R4 data after select fall", int'(last_wd), 8'h77);

    // opcode sweep over pointer fields
    for (int op = 0; op < 16; op++) begin
      for (int s = 0; s < 4; s++) begin
        logic [3:0] sel;
        logic [3:0] opv;
        logic [7:0] dat, exp_rd;
        bit valid, three, rd;
        int e0, e1, e2, e3;
        sel = (s == 0) ? 4'h0 : (s == 1) ? 4'h6 : (s == 2) ? 4'hC : 4'hF;
        opv = 4'(op);
        wip = sel[0];
        dat = {opv, sel} ^ 8'h3C;
        rd    = (opv == 4'h9) || (opv == 4'hB) || (opv == 4'h5);
        three = rd || (opv == 4'hA) || (opv == 4'hC);
        valid = three || (opv == 4'hD) || (opv == 4'hE) || (opv == 4'h2);
        exp_rd = (opv == 4'h9) ? 8'hC6 :
                 (opv == 4'hB) ? ({sel[1:0], sel[3:2], 4'h3} ^ 8'h5A) :
                 {7'b0, sel[0]};
        e0 = (opv == 4'hA) ? 1 : 0;
        e1 = (opv == 4'hC) ? 1 : 0;
        e2 = (opv == 4'hD && sel[1:0] == 2'b00) ? 1 : 0;
        e3 = (opv == 4'hE && sel[1:0] == 2'b00) ? 1 : 0;
        snap();
        cs_start();
        send_byte(idb, got);
        send_byte({opv, sel}, got);
        if (valid) chk("R3 pointers", int'({reg_sel, bank_sel}),
                       int'({sel[3:2], sel[1:0]}));
        if (opv == 4'h2) begin
          sck_bit(1'b1, b1); sck_bit(1'b1, b1); sck_bit(1'b0, b1);
        end else if (three) begin
          send_byte(rd ? 8'h00 : dat, got);
          if (rd) begin
            chk("R6 read byte", int'(got), int'(exp_rd));
            wait_n(2);
            chk("R7 so_oe during read", int'(so_oe), 1);
          end
        end else if (!valid) begin
          send_byte(8'hFF, got);
        end
        cs_end();
        chk("R7 so_oe after select", int'(so_oe), 0);
        if (valid)
          chk_delta("R2 R4 R5 R8 strobes", e0, e1, e2, e3,
                    (opv == 4'h2) ? 2 : 0, (opv == 4'h2) ? 1 : 0);
        else
          chk_delta("R2 undefined opcode", 0, 0, 0, 0, 0, 0);
        if (e0 == 1 || e1 == 1) chk("R4 write data", int'(last_wd), int'(dat));
      end
    end

    // R1: identification byte grid
    for (int n = 0; n < 16; n++) begin
      for (int a = 0; a < 4; a++) begin
        logic [7:0] id;
        int acc;
        id  = {4'(n), 2'b00, 2'(a)};
        acc = (n == 5 && 2'(a) == strap) ? 1 : 0;
        snap();
        cs_start();
        send_byte(id, got);
        send_byte(8'hA4, got);
        send_byte(8'(n * 16 + a), got);
        cs_end();
        chk("R1 identification match", cnt[0] - base[0], acc);
        if (acc == 1) chk("R1 accepted data", int'(last_wd), n * 16 + a);
      end
    end
    for (int m = 1; m < 4; m++) begin
      snap();
      cs_start();
      send_byte({4'b0101, 2'(m), strap}, got);
      send_byte(8'hA0, got);
      send_byte(8'h11, got);
      cs_end();
      chk("R1 nonzero pad bits", cnt[0] - base[0], 0);
    end

    // R4: partial and overlong writes abort
    snap();
    cs_start();
    send_byte(idb, got); send_byte(8'hA0, got); send_byte(8'h12, got);
    sck_bit(1'b1, b1); sck_bit(1'b0, b1); sck_bit(1'b1, b1);
    cs_end();
    chk_delta("R4 extra bits abort", 0, 0, 0, 0, 0, 0);
    snap();
    cs_start();
    send_byte(idb, got); send_byte(8'hC4, got);
    for (int i = 0; i < 5; i++) sck_bit(1'b1, b1);
    cs_end();
    chk_delta("R4 short data aborts", 0, 0, 0, 0, 0, 0);
    snap();
    cs_start();
    send_byte(idb, got); send_byte(8'hD8, got); send_byte(8'h00, got);
    cs_end();
    chk_delta("R5 transfer with extra byte aborts", 0, 0, 0, 0, 0, 0);

    // R8: clocks after select rise do not step
    snap();
    for (int i = 0; i < 3; i++) sck_bit(1'b1, b1);
    wait_n(6);
    chk_delta("R8 no steps after release", 0, 0, 0, 0, 0, 0);

    // R9: pause in a read and in a write
    cs_start();
    send_byte(idb, got); send_byte(8'h90, got);
    for (int i = 7; i >= 5; i--) begin sck_bit(1'b0, b1); got[i] = b1; end
    pause_toggle(1'b1);
    for (int i = 4; i >= 0; i--) begin sck_bit(1'b0, b1); got[i] = b1; end
    chk("R9 read across pause", int'(got), 8'hC6);
    cs_end();
    snap();
    cs_start();
    send_byte(idb, got); send_byte(8'hA0, got);
    for (int i = 7; i >= 4; i--) sck_bit(1'(8'h5A >> i), b1);
    pause_toggle(1'b1);
    for (int i = 3; i >= 0; i--) sck_bit(1'(8'h5A >> i), b1);
    cs_end();
    chk_delta("R9 write across pause", 1, 0, 0, 0, 0, 0);
    chk("R9 write data across pause", int'(last_wd), 8'h5A);

    chk("R6 so only changes on falling sck", so_glitch, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule